// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five interrupt request lines is served next. One line is non-maskable (the top-priority emergency line), three are maskable lines with fixed service addresses, and one is a general maskable line whose service address comes from the requesting peripheral. Each line has its own sensing rule. The emergency line needs a rising edge and must still be high when it is sampled. The highest maskable line latches a rising edge. The remaining lines are level-sensitive.

The processor marks every instruction boundary with a one-cycle strobe. Requests are examined only on that strobe. When a line wins, the block returns a 16-bit service vector. For the general line it first raises an acknowledge and then decodes a restart opcode that the peripheral places on an 8-bit bus. The processor controls the block with four commands: enable-all, disable-all, write-masks and read-status. Accepting any request clears the global enable, so the service routine has to enable interrupts again itself.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three line masks are 1 (masked), the edge pending latch is clear, and `svc_valid`, `ack_out`, `op_err` and `stat_valid` are 0.
- R2: When several requests are eligible on the same boundary, the winner is picked in this order: `nmi_req`, `edge_req`, `lvl_hi_req`, `lvl_lo_req`, `ext_req`.
- R3: An accepted vectored line sets `svc_valid` high for one cycle, in the cycle after the boundary strobe. `svc_vector` is then 0x0024 for `nmi_req`, 0x003C for `edge_req`, 0x0034 for `lvl_hi_req` and 0x002C for `lvl_lo_req`.
- R4: `nmi_req` ignores the global enable and the masks. It is accepted only if it has risen since it was last low and is still high at the boundary. Once accepted, it must go low and rise again before it is accepted again.
- R5: A rising edge on `edge_req` sets a pending latch, which then holds the request after the input falls. The latch is cleared when the line is accepted, or by a write-masks command with bit 4 set.
- R6: `lvl_hi_req`, `lvl_lo_req` and `ext_req` are recognised only while they are high at the boundary strobe.
- R7: Command code 0 sets the global enable and code 1 clears it. While the enable is clear, only `nmi_req` can be accepted.
- R8: Write-masks (code 2) loads mask bits from `cmd_wdata[2:0]` (bit 0 for `lvl_lo_req`, bit 1 for `lvl_hi_req`, bit 2 for `edge_req`; 1 = masked), but only when bit 3 is 1. A masked line is never accepted.
- R9: Read-status (code 3) sets `stat_valid` in the next cycle. `stat_data` then holds: bits [2:0] the masks, bit 3 the global enable, bit 4 `lvl_lo_req`, bit 5 `lvl_hi_req`, bit 6 the edge pending latch, bit 7 zero.
- R10: Requests are acted on only in a cycle with `insn_bnd` high, and accepting any request clears the global enable.
- R11: Accepting `ext_req` raises `ack_out` from the next cycle until a `bus_valid` cycle. A bus byte of the form 11nnn111 then gives one `svc_valid` pulse with vector n×8, and `ack_out` falls.
- R12: Any other bus byte during acknowledge gives a one-cycle `op_err` pulse and no `svc_valid`, and `ack_out` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, edge plus level |
| edge_req | input | 1 | Maskable request, rising edge latched |
| lvl_hi_req | input | 1 | Maskable level request, third priority |
| lvl_lo_req | input | 1 | Maskable level request, fourth priority |
| ext_req | input | 1 | General level request, vector from bus |
| insn_bnd | input | 1 | Instruction boundary strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 enable, 1 disable, 2 write masks, 3 read status |
| cmd_wdata | input | 8 | Write-masks data byte |
| stat_valid | output | 1 | Status byte valid |
| stat_data | output | 8 | Status byte |
| svc_valid | output | 1 | Service vector valid pulse |
| svc_vector | output | 16 | Service address |
| ack_out | output | 1 | Acknowledge to the general-line peripheral |
| bus_valid | input | 1 | Peripheral has placed an opcode on the bus |
| bus_data | input | 8 | Restart opcode from the peripheral |
| op_err | output | 1 | Bad opcode pulse |

## Verification
On every cycle the assertions check the following: the arbiter grants at most one line, acceptance clears the enable, the emergency line is served whatever the enable holds and is disarmed straight after service, the edge latch is set only by an edge, the acknowledge is held until the bus byte arrives, and error and vector pulses never occur together. Other behaviour can only be shown by the bench's scenarios: the priority order among real competing inputs, the loss of a level request that drops before the boundary, the masking and the mask-write guard bit, the bit layout of the status byte, and the decoding of valid and invalid restart opcodes. A behavioural reference model in the bench is compared on every clock as well.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC   = 5;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int VEC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NMASK  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NMI  = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_LHI  = 3'd2,
        SRC_LLO  = 3'd3,
        SRC_EXT  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        CMD_EN   = 2'd0,
        CMD_DIS  = 2'd1,
        CMD_MASK = 2'd2,
        CMD_READ = 2'd3
    } cmd_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_WAIT_OP = 1'b1
    } st_e;

    typedef struct packed {
        logic             zero;
        logic             pend_edge;
        logic             lvl_hi;
        logic             lvl_lo;
        logic             ie;
        logic [NMASK-1:0] mask;
    } status_t;

    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_LHI  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LLO  = 16'h002C;

    function automatic logic [VEC_W-1:0] fixed_vector(input src_e s);
        case (s)
            SRC_NMI:  return VEC_NMI;
            SRC_EDGE: return VEC_EDGE;
            SRC_LHI:  return VEC_LHI;
            SRC_LLO:  return VEC_LLO;
            default:  return '0;
        endcase
    endfunction

    function automatic logic restart_ok(input logic [BYTE_W-1:0] b);
        return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    endfunction

    function automatic logic [VEC_W-1:0] restart_vector(input logic [BYTE_W-1:0] b);
        return {{(VEC_W-6){1'b0}}, b[5:3], 3'b000};
    endfunction
endpackage

// File: rtl/vic_sense.sv
module vic_sense
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic edge_in,
    input  logic take_nmi,
    input  logic take_edge,
    input  logic clr_edge,
    output logic nmi_live,
    output logic edge_live,
    output logic edge_pend
);
    logic nmi_prev, nmi_armed, edge_prev;
    logic nmi_rise, edge_rise;

    assign nmi_rise  = nmi_in & ~nmi_prev;
    assign edge_rise = edge_in & ~edge_prev;

    // armed survives only while the input stays high after its rise
    assign nmi_live  = nmi_in & (nmi_armed | nmi_rise);
    assign edge_live = edge_pend | edge_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev  <= 1'b0;
            nmi_armed <= 1'b0;
            edge_prev <= 1'b0;
            edge_pend <= 1'b0;
        end else begin
            nmi_prev  <= nmi_in;
            edge_prev <= edge_in;
            nmi_armed <= nmi_live & ~take_nmi;
            edge_pend <= edge_live & ~take_edge & ~clr_edge;
        end
    end

    p_nmi_rearm_r4: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> !nmi_live);

    p_pend_from_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_pend) |-> $past(edge_in));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int N   = 5,
    parameter int IDX = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic           any,
    output logic [IDX-1:0] idx
);
    // index 0 is the highest priority
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_pri
            if (gi == 0) begin : g_top
                assign grant[gi] = req[gi];
            end else begin : g_rest
                assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX'(i);
        end
    end
endmodule

// File: rtl/vic_cfg.sv
module vic_cfg
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [4:0]        wdata,
    input  logic              accept,
    input  logic              lvl_hi,
    input  logic              lvl_lo,
    input  logic              pend_edge,
    output logic              ie,
    output logic [NMASK-1:0]  mask,
    output logic              clr_edge,
    output logic              stat_valid,
    output logic [BYTE_W-1:0] stat_data
);
    cmd_e    op;
    status_t snap;

    assign op       = cmd_e'(cmd_op);
    assign clr_edge = cmd_valid && (op == CMD_MASK) && wdata[4];

    always_comb begin
        snap.zero      = 1'b0;
        snap.pend_edge = pend_edge;
        snap.lvl_hi    = lvl_hi;
        snap.lvl_lo    = lvl_lo;
        snap.ie        = ie;
        snap.mask      = mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie         <= 1'b0;
            mask       <= '1;
            stat_valid <= 1'b0;
            stat_data  <= '0;
        end else begin
            stat_valid <= 1'b0;
            if (accept) begin
                ie <= 1'b0;
            end else if (cmd_valid && op == CMD_EN) begin
                ie <= 1'b1;
            end else if (cmd_valid && op == CMD_DIS) begin
                ie <= 1'b0;
            end
            if (cmd_valid && op == CMD_MASK && wdata[3]) begin
                mask <= wdata[NMASK-1:0];
            end
            if (cmd_valid && op == CMD_READ) begin
                stat_valid <= 1'b1;
                stat_data  <= snap;
            end
        end
    end

    p_disable_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == CMD_DIS) |=> !ie);

    p_mask_guard_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == CMD_MASK && !wdata[3]) |=> $stable(mask));

    p_stat_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> $past(cmd_valid && op == CMD_READ));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_req,
    input  logic              edge_req,
    input  logic              lvl_hi_req,
    input  logic              lvl_lo_req,
    input  logic              ext_req,
    input  logic              insn_bnd,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic              stat_valid,
    output logic [BYTE_W-1:0] stat_data,
    output logic              svc_valid,
    output logic [VEC_W-1:0]  svc_vector,
    output logic              ack_out,
    input  logic              bus_valid,
    input  logic [BYTE_W-1:0] bus_data,
    output logic              op_err
);
    st_e              state;
    logic             ie, clr_edge;
    logic [NMASK-1:0] mask;
    logic             nmi_live, edge_live, edge_pend;
    logic [NSRC-1:0]  elig, grant;
    logic             any;
    logic [SRC_W-1:0] win;
    src_e             win_src;
    logic             take, take_nmi, take_edge;
    logic             unused_cmd_bits;

    assign unused_cmd_bits = ^cmd_wdata[BYTE_W-1:5];

    vic_sense u_sense (
        .clk       (clk),
        .rst       (rst),
        .nmi_in    (nmi_req),
        .edge_in   (edge_req),
        .take_nmi  (take_nmi),
        .take_edge (take_edge),
        .clr_edge  (clr_edge),
        .nmi_live  (nmi_live),
        .edge_live (edge_live),
        .edge_pend (edge_pend)
    );

    always_comb begin
        elig           = '0;
        elig[SRC_NMI]  = nmi_live;
        elig[SRC_EDGE] = ie & ~mask[2] & edge_live;
        elig[SRC_LHI]  = ie & ~mask[1] & lvl_hi_req;
        elig[SRC_LLO]  = ie & ~mask[0] & lvl_lo_req;
        elig[SRC_EXT]  = ie & ext_req;
    end

    vic_arb #(.N(NSRC), .IDX(SRC_W)) u_arb (
        .req   (elig),
        .grant (grant),
        .any   (any),
        .idx   (win)
    );

    assign win_src   = src_e'(win);
    assign take      = insn_bnd && (state == ST_IDLE) && any;
    assign take_nmi  = take && (win_src == SRC_NMI);
    assign take_edge = take && (win_src == SRC_EDGE);
    assign ack_out   = (state == ST_WAIT_OP);

    vic_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .wdata      (cmd_wdata[4:0]),
        .accept     (take),
        .lvl_hi     (lvl_hi_req),
        .lvl_lo     (lvl_lo_req),
        .pend_edge  (edge_pend),
        .ie         (ie),
        .mask       (mask),
        .clr_edge   (clr_edge),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            svc_valid  <= 1'b0;
            svc_vector <= '0;
            op_err     <= 1'b0;
        end else begin
            svc_valid <= 1'b0;
            op_err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        if (win_src == SRC_EXT) begin
                            state <= ST_WAIT_OP;
                        end else begin
                            svc_valid  <= 1'b1;
                            svc_vector <= fixed_vector(win_src);
                        end
                    end
                end
                ST_WAIT_OP: begin
                    if (bus_valid) begin
                        state <= ST_IDLE;
                        if (restart_ok(bus_data)) begin
                            svc_valid  <= 1'b1;
                            svc_vector <= restart_vector(bus_data);
                        end else begin
                            op_err <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_one_winner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_nmi_served_r4: assert property (@(posedge clk) disable iff (rst)
        (insn_bnd && !ack_out && nmi_live) |=> (svc_valid && svc_vector == VEC_NMI));

    p_accept_clears_ie_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> !ie);

    p_ack_held_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_out && !bus_valid) |=> ack_out);

    p_err_excl_r12: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (!svc_valid && !ack_out));
endmodule

// File: tb/sim_vic_ctrl.sv
module sim_vic_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 0, edge_req = 0, lvl_hi_req = 0, lvl_lo_req = 0, ext_req = 0;
    logic        insn_bnd = 0, cmd_valid = 0, bus_valid = 0;
    logic [1:0]  cmd_op = 0;
    logic [7:0]  cmd_wdata = 0, bus_data = 0;
    logic        stat_valid, svc_valid, ack_out, op_err;
    logic [7:0]  stat_data;
    logic [15:0] svc_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vic_ctrl u0 (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .edge_req(edge_req),
        .lvl_hi_req(lvl_hi_req), .lvl_lo_req(lvl_lo_req), .ext_req(ext_req),
        .insn_bnd(insn_bnd), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .stat_valid(stat_valid), .stat_data(stat_data),
        .svc_valid(svc_valid), .svc_vector(svc_vector), .ack_out(ack_out),
        .bus_valid(bus_valid), .bus_data(bus_data), .op_err(op_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_ie, m_p7, m_nprev, m_narm, m_eprev, m_wait;
    bit [2:0] m_mask;
    bit       m_svc, m_err, m_sv;
    int       m_vec, m_sd;

    always @(posedge clk) begin
        if (rst) begin
            m_ie = 0; m_p7 = 0; m_nprev = 0; m_narm = 0; m_eprev = 0; m_wait = 0;
            m_mask = 3'b111; m_svc = 0; m_err = 0; m_sv = 0; m_vec = 0; m_sd = 0;
        end else begin
            bit nmi_ok, e_ok, accepted, tk_n, tk_e;
            int pick;
            nmi_ok = nmi_req && (m_narm || !m_nprev);
            e_ok   = m_p7 || (edge_req && !m_eprev);
            m_svc = 0; m_err = 0; m_sv = 0;
            accepted = 0; tk_n = 0; tk_e = 0; pick = -1;
            if (m_wait) begin
                if (bus_valid) begin
                    m_wait = 0;
                    if (bus_data[7:6] == 2'b11 && bus_data[2:0] == 3'b111) begin
                        m_svc = 1; m_vec = int'(bus_data[5:3]) * 8;
                    end else m_err = 1;
                end
            end else if (insn_bnd) begin
                if (nmi_ok) pick = 0;
                else if (m_ie && !m_mask[2] && e_ok) pick = 1;
                else if (m_ie && !m_mask[1] && lvl_hi_req) pick = 2;
                else if (m_ie && !m_mask[0] && lvl_lo_req) pick = 3;
                else if (m_ie && ext_req) pick = 4;
                accepted = (pick >= 0);
                case (pick)
                    0: begin m_svc = 1; m_vec = 'h24; tk_n = 1; end
                    1: begin m_svc = 1; m_vec = 'h3C; tk_e = 1; end
                    2: begin m_svc = 1; m_vec = 'h34; end
                    3: begin m_svc = 1; m_vec = 'h2C; end
                    4: m_wait = 1;
                    default: ;
                endcase
            end
            if (cmd_valid && cmd_op == 3) begin
                m_sv = 1;
                m_sd = {1'b0, m_p7, lvl_hi_req, lvl_lo_req, m_ie, m_mask};
            end
            m_narm = nmi_ok && !tk_n;
            m_p7   = e_ok && !tk_e && !(cmd_valid && cmd_op == 2 && cmd_wdata[4]);
            if (cmd_valid && cmd_op == 2 && cmd_wdata[3]) m_mask = cmd_wdata[2:0];
            if (accepted) m_ie = 0;
            else if (cmd_valid && cmd_op == 0) m_ie = 1;
            else if (cmd_valid && cmd_op == 1) m_ie = 0;
            m_nprev = nmi_req;
            m_eprev = edge_req;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(svc_valid == m_svc, "R3 model svc_valid", svc_valid, m_svc);
            if (m_svc) chk(svc_vector == m_vec[15:0], "R3 model svc_vector", svc_vector, m_vec);
            chk(ack_out == m_wait, "R11 model ack_out", ack_out, m_wait);
            chk(op_err == m_err, "R12 model op_err", op_err, m_err);
            chk(stat_valid == m_sv, "R9 model stat_valid", stat_valid, m_sv);
            if (m_sv) chk(stat_data == m_sd[7:0], "R9 model stat_data", stat_data, m_sd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [7:0] d);
        cmd_valid = 1; cmd_op = op; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0; cmd_wdata = 0;
    endtask

    task automatic status_is(input int exp, input string tag);
        cmd_valid = 1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 0;
        chk(stat_valid && stat_data == exp[7:0], tag, stat_data, exp);
    endtask

    task automatic boundary_expect(input bit v, input int vec, input string tag);
        insn_bnd = 1;
        @(negedge clk);
        insn_bnd = 0;
        chk(svc_valid == v, tag, svc_valid, v);
        if (v) chk(svc_vector == vec[15:0], tag, svc_vector, vec);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        chk(!svc_valid && !ack_out && !op_err && !stat_valid, "R1 outputs idle", svc_valid, 0);
        status_is('h07, "R1 R9 status after reset");

        // R7 R8 enable and unmask
        cmd(2'd0, 0);
        cmd(2'd2, 8'h08);
        status_is('h08, "R7 R8 status after enable/unmask");

        // R2 R3 priority among level lines and general line
        lvl_lo_req = 1; lvl_hi_req = 1; ext_req = 1;
        step(1);
        boundary_expect(1, 'h34, "R2 R3 level-hi wins");
        status_is('h30, "R10 enable cleared by accept");
        boundary_expect(0, 0, "R7 R10 nothing while disabled");

        cmd(2'd0, 0);
        boundary_expect(1, 'h34, "R6 level-hi still high");
        lvl_hi_req = 0;
        cmd(2'd0, 0);
        boundary_expect(1, 'h2C, "R3 level-lo vector");
        lvl_lo_req = 0;
        cmd(2'd0, 0);
        boundary_expect(0, 0, "R11 general line no direct vector");
        chk(ack_out == 1, "R11 ack raised", ack_out, 1);
        step(2);
        chk(ack_out == 1, "R11 ack held", ack_out, 1);
        bus_data = 8'hEF; bus_valid = 1;
        @(negedge clk);
        bus_valid = 0;
        chk(svc_valid && svc_vector == 16'h0028, "R11 restart 5 vector", svc_vector, 'h28);
        chk(ack_out == 0, "R11 ack released", ack_out, 0);

        // R12 bad opcode
        cmd(2'd0, 0);
        boundary_expect(0, 0, "R11 general line accepted");
        bus_data = 8'h3C; bus_valid = 1;
        @(negedge clk);
        bus_valid = 0;
        chk(op_err && !svc_valid && !ack_out, "R12 bad opcode error", op_err, 1);
        ext_req = 0;

        // R5 edge latch
        cmd(2'd0, 0);
        edge_req = 1; step(1); edge_req = 0; step(2);
        status_is('h48, "R5 pending latched after pulse");
        boundary_expect(1, 'h3C, "R3 R5 edge line vector");
        status_is('h00, "R5 pending cleared by accept");
        cmd(2'd2, 8'h0C);
        cmd(2'd0, 0);
        edge_req = 1; step(1); edge_req = 0; step(1);
        boundary_expect(0, 0, "R8 masked edge line ignored");
        status_is('h4C, "R5 R8 masked pending held");
        cmd(2'd2, 8'h07);
        status_is('h4C, "R8 write without load bit ignored");
        cmd(2'd2, 8'h18);
        status_is('h08, "R5 mask write clears pending");
        boundary_expect(0, 0, "R5 nothing pending after clear");

        // R4 non-maskable line
        cmd(2'd1, 0);
        nmi_req = 1; step(1);
        boundary_expect(1, 'h24, "R4 R7 nmi ignores disable");
        boundary_expect(0, 0, "R4 nmi needs new edge");
        nmi_req = 0; step(1); nmi_req = 1; step(1); nmi_req = 0; step(1);
        boundary_expect(0, 0, "R4 nmi dropped before boundary");
        nmi_req = 1; lvl_hi_req = 1; ext_req = 1;
        cmd(2'd0, 0);
        boundary_expect(1, 'h24, "R2 nmi beats all");
        nmi_req = 0; lvl_hi_req = 0; ext_req = 0;

        // R10 no action without boundary, R6 level lost
        cmd(2'd0, 0);
        lvl_lo_req = 1;
        step(5);
        chk(!svc_valid && !ack_out, "R10 no boundary no service", svc_valid, 0);
        lvl_lo_req = 0; step(1);
        boundary_expect(0, 0, "R6 level dropped before boundary");
        step(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule